// File: doc/BRIEF.md
# Polyphase Decimating FIR Sequencer

This block runs one decimating FIR filter over a complex (I/Q) sample stream. Incoming samples are written into a circular history buffer. A modulo-M input counter picks which input phase starts a filter computation. A single multiply-accumulate engine then walks the taps one per clock. For each tap it pairs the newest sample with coefficient 0, the sample before it with coefficient 1, and so on. It reads each coefficient from an external 256-word coefficient memory that answers in the same cycle.

Two settings are shadowed. The coefficient base pointer and the selected decimation phase are copied into working registers only when a computation starts. The host can therefore rewrite them while a filter is running without corrupting the output in flight. One control bit chooses whether the filter takes this channel's own CIC stream or a neighbouring channel's stream. A second control bit bypasses the filter and captures the upper bits of each incoming sample into a pair of test registers.

Top module: `polyfir_seq`

## Requirements
- R1: After reset, outValid, overrun, testI and testQ are all zero.
- R2: With cfgSrcSel = 1 the filter consumes nbrValid/nbrI/nbrQ. With cfgSrcSel = 0 it consumes ownValid/ownI/ownQ. The unselected stream has no effect on any output.
- R3: A modulo counter counts the accepted samples and wraps after the count cfgDecM1, so the decimation is cfgDecM1 + 1. A filter start is requested by the accepted sample that arrives while the counter equals the latched phase.
- R4: Each output equals the sum, over k = 0..cfgTapsM1, of sample[newest - k] times coef[(base + k) mod 256]. The newest sample is the one that triggered the start. Results are signed, ACC_W bits wide, computed separately for I and Q.
- R5: outValid pulses for one cycle, cfgTapsM1 + 1 clock edges after the edge that accepted the triggering sample.
- R6: cfgCoefOffset is sampled only at a filter start. A change made during a computation first affects the next output.
- R7: cfgPhase is sampled only at an accepted filter start. After reset the latched phase is 0.
- R8: While cfgBypass = 1, each selected valid sample loads its 16 most significant bits (bits 19..4 at the default width) into testI/testQ. The sample enters neither the history buffer nor the phase counter, and no output is produced. Otherwise testI/testQ hold their value.
- R9: A start request that arrives while a computation is still running, and not on its final tap cycle, is dropped. It raises overrun for one cycle, and the running computation is unaffected. A request on the final tap cycle is accepted.
- R10: While a computation runs, coefAddr starts at the latched base and steps by one each cycle, wrapping from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ownValid | input | 1 | This channel's CIC sample strobe |
| ownI | input | DATA_W | This channel's I sample |
| ownQ | input | DATA_W | This channel's Q sample |
| nbrValid | input | 1 | Neighbour channel's CIC sample strobe |
| nbrI | input | DATA_W | Neighbour I sample |
| nbrQ | input | DATA_W | Neighbour Q sample |
| cfgDecM1 | input | CFG_W | Decimation minus one |
| cfgPhase | input | CFG_W | Decimation phase that triggers a computation |
| cfgTapsM1 | input | CFG_W | Number of taps minus one |
| cfgCoefOffset | input | COEF_AW | Coefficient base address |
| cfgBypass | input | 1 | Bypass the filter into the test registers |
| cfgSrcSel | input | 1 | 1 selects the neighbour stream |
| coefAddr | output | COEF_AW | Coefficient memory read address |
| coefData | input | COEF_W | Coefficient read data, same cycle as the address |
| outValid | output | 1 | Filter result strobe |
| outI | output | ACC_W | Filter result, I |
| outQ | output | ACC_W | Filter result, Q |
| overrun | output | 1 | Pulse when a start request was dropped |
| testI | output | TEST_W | Bypass capture, I |
| testQ | output | TEST_W | Bypass capture, Q |

## Verification
The checks assume the host keeps cfgPhase no larger than cfgDecM1. They also assume that the taps plus the samples arriving during one computation fit inside the 256-entry history, and that the coefficient memory answers combinationally. The stimulus keeps every phase setting within the current decimation. Before the decimation is shortened, the phase is first returned to 0 and a start is allowed to latch it. Filters stay at eight taps or fewer, so no buffer entry in use is overwritten. The bench's coefficient memory is a plain combinational array.

// File: rtl/polyfir_pkg.sv
package polyfir_pkg;
  typedef struct packed {
    logic wrEn;     // accepted sample written into history
    logic start;    // new computation begins at this edge
    logic macEn;    // a tap is accumulated at this edge
    logic lastTap;  // current tap is the final one
    logic testLd;   // bypass capture into test registers
  } fir_strobe_t;
endpackage

// File: rtl/polyfir_ctrl.sv
module polyfir_ctrl
  import polyfir_pkg::*;
#(
  parameter int CFG_W   = 8,
  parameter int COEF_AW = 8,
  parameter int BUF_AW  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               selValid,
  input  logic               cfgBypass,
  input  logic [CFG_W-1:0]   cfgDecM1,
  input  logic [CFG_W-1:0]   cfgPhase,
  input  logic [CFG_W-1:0]   cfgTapsM1,
  input  logic [COEF_AW-1:0] cfgCoefOffset,
  output fir_strobe_t        stb,
  output logic [BUF_AW-1:0]  wrAddr,
  output logic [BUF_AW-1:0]  rdAddr,
  output logic [COEF_AW-1:0] coefAddr,
  output logic               busy,
  output logic               overrun
);
  logic [CFG_W-1:0]   phaseCnt, phaseSh, tapsSh, tapIdx;
  logic [COEF_AW-1:0] baseSh;
  logic [BUF_AW-1:0]  wrPtr, headPtr;
  logic accept, startReq, lastTap, startOk;

  assign accept   = selValid && !cfgBypass;
  assign startReq = accept && (phaseCnt == phaseSh);
  assign lastTap  = busy && (tapIdx == tapsSh);
  assign startOk  = startReq && (!busy || lastTap);

  always_comb begin
    stb.wrEn    = accept;
    stb.start   = startOk;
    stb.macEn   = busy;
    stb.lastTap = lastTap;
    stb.testLd  = selValid && cfgBypass;
  end

  assign wrAddr   = wrPtr;
  assign rdAddr   = headPtr - BUF_AW'(tapIdx);
  assign coefAddr = baseSh + COEF_AW'(tapIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      phaseSh  <= '0;
      tapsSh   <= '0;
      tapIdx   <= '0;
      baseSh   <= '0;
      wrPtr    <= '0;
      headPtr  <= '0;
      busy     <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      overrun <= startReq && busy && !lastTap;
      if (accept) begin
        wrPtr    <= wrPtr + 1'b1;
        phaseCnt <= (phaseCnt >= cfgDecM1) ? '0 : phaseCnt + 1'b1;
      end
      if (startOk) begin
        busy    <= 1'b1;
        tapIdx  <= '0;
        tapsSh  <= cfgTapsM1;
        baseSh  <= cfgCoefOffset;
        phaseSh <= cfgPhase;
        headPtr <= wrPtr;
      end else if (lastTap) begin
        busy <= 1'b0;
      end else if (busy) begin
        tapIdx <= tapIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/polyfir_dp.sv
module polyfir_dp
  import polyfir_pkg::*;
#(
  parameter int DATA_W    = 20,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 40,
  parameter int TEST_W    = 16,
  parameter int BUF_DEPTH = 256,
  localparam int BUF_AW   = $clog2(BUF_DEPTH),
  localparam int PROD_W   = DATA_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fir_strobe_t              stb,
  input  logic                     srcSel,
  input  logic signed [DATA_W-1:0] ownI,
  input  logic signed [DATA_W-1:0] ownQ,
  input  logic signed [DATA_W-1:0] nbrI,
  input  logic signed [DATA_W-1:0] nbrQ,
  input  logic [BUF_AW-1:0]        wrAddr,
  input  logic [BUF_AW-1:0]        rdAddr,
  input  logic signed [COEF_W-1:0] coefData,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outI,
  output logic signed [ACC_W-1:0]  outQ,
  output logic [TEST_W-1:0]        testI,
  output logic [TEST_W-1:0]        testQ
);
  logic signed [DATA_W-1:0] histI [BUF_DEPTH];
  logic signed [DATA_W-1:0] histQ [BUF_DEPTH];
  logic signed [DATA_W-1:0] selI, selQ;
  logic signed [PROD_W-1:0] prodI, prodQ;
  logic signed [ACC_W-1:0]  accI, accQ, sumI, sumQ;

  assign selI  = srcSel ? nbrI : ownI;
  assign selQ  = srcSel ? nbrQ : ownQ;
  assign prodI = histI[rdAddr] * coefData;
  assign prodQ = histQ[rdAddr] * coefData;
  assign sumI  = accI + ACC_W'(prodI);
  assign sumQ  = accQ + ACC_W'(prodQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_DEPTH; i++) begin
        histI[i] <= '0;
        histQ[i] <= '0;
      end
    end else if (stb.wrEn) begin
      histI[wrAddr] <= selI;
      histQ[wrAddr] <= selQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accI     <= '0;
      accQ     <= '0;
      outI     <= '0;
      outQ     <= '0;
      outValid <= 1'b0;
      testI    <= '0;
      testQ    <= '0;
    end else begin
      outValid <= stb.macEn && stb.lastTap;
      if (stb.macEn && stb.lastTap) begin
        outI <= sumI;
        outQ <= sumQ;
      end
      if (stb.start) begin
        accI <= '0;
        accQ <= '0;
      end else if (stb.macEn) begin
        accI <= sumI;
        accQ <= sumQ;
      end
      if (stb.testLd) begin
        testI <= selI[DATA_W-1 -: TEST_W];
        testQ <= selQ[DATA_W-1 -: TEST_W];
      end
    end
  end
endmodule

// File: rtl/polyfir_seq.sv
module polyfir_seq
  import polyfir_pkg::*;
#(
  parameter int DATA_W     = 20,
  parameter int COEF_W     = 16,
  parameter int ACC_W      = 40,
  parameter int TEST_W     = 16,
  parameter int CFG_W      = 8,
  parameter int COEF_DEPTH = 256,
  parameter int BUF_DEPTH  = 256,
  localparam int COEF_AW   = $clog2(COEF_DEPTH),
  localparam int BUF_AW    = $clog2(BUF_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ownValid,
  input  logic signed [DATA_W-1:0] ownI,
  input  logic signed [DATA_W-1:0] ownQ,
  input  logic                     nbrValid,
  input  logic signed [DATA_W-1:0] nbrI,
  input  logic signed [DATA_W-1:0] nbrQ,
  input  logic [CFG_W-1:0]         cfgDecM1,
  input  logic [CFG_W-1:0]         cfgPhase,
  input  logic [CFG_W-1:0]         cfgTapsM1,
  input  logic [COEF_AW-1:0]       cfgCoefOffset,
  input  logic                     cfgBypass,
  input  logic                     cfgSrcSel,
  output logic [COEF_AW-1:0]       coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outI,
  output logic signed [ACC_W-1:0]  outQ,
  output logic                     overrun,
  output logic [TEST_W-1:0]        testI,
  output logic [TEST_W-1:0]        testQ
);
  fir_strobe_t       stb;
  logic [BUF_AW-1:0] wrAddr, rdAddr;
  logic              busy, selValid, lastTap;

  assign selValid = cfgSrcSel ? nbrValid : ownValid;
  assign lastTap  = stb.lastTap;

  polyfir_ctrl #(.CFG_W(CFG_W), .COEF_AW(COEF_AW), .BUF_AW(BUF_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .selValid(selValid), .cfgBypass(cfgBypass),
    .cfgDecM1(cfgDecM1), .cfgPhase(cfgPhase), .cfgTapsM1(cfgTapsM1),
    .cfgCoefOffset(cfgCoefOffset), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .coefAddr(coefAddr), .busy(busy), .overrun(overrun)
  );

  polyfir_dp #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .TEST_W(TEST_W),
               .BUF_DEPTH(BUF_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .srcSel(cfgSrcSel),
    .ownI(ownI), .ownQ(ownQ), .nbrI(nbrI), .nbrQ(nbrQ),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .coefData(coefData),
    .outValid(outValid), .outI(outI), .outQ(outQ), .testI(testI), .testQ(testQ)
  );
endmodule

// File: rtl/polyfir_seq_chk.sv
module polyfir_seq_chk #(
  parameter int COEF_AW = 8,
  parameter int TEST_W  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               selValid,
  input logic               cfgBypass,
  input logic               busy,
  input logic               lastTap,
  input logic [COEF_AW-1:0] coefAddr,
  input logic               outValid,
  input logic               overrun,
  input logic [TEST_W-1:0]  testI,
  input logic [TEST_W-1:0]  testQ
);
  // R9: a dropped request needs a filtered sample on the previous edge
  p_overrun_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(selValid && !cfgBypass));

  // R10: the coefficient address advances by one per running tap
  p_coef_walk_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy && !lastTap) |-> coefAddr == $past(coefAddr) + 1'b1);

  // R8: test registers change only on a bypassed sample
  p_test_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgBypass && selValid) |-> ($stable(testI) && $stable(testQ)));

  // R5: a result only follows a running computation
  p_out_after_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(busy));
endmodule

bind polyfir_seq polyfir_seq_chk #(.COEF_AW(COEF_AW), .TEST_W(TEST_W)) u_chk (
  .clk(clk), .rstN(rstN), .selValid(selValid), .cfgBypass(cfgBypass),
  .busy(busy), .lastTap(lastTap), .coefAddr(coefAddr), .outValid(outValid),
  .overrun(overrun), .testI(testI), .testQ(testQ)
);

// File: tb/polyfir_seq_tb.sv
module polyfir_seq_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic ownValid = 1'b0, nbrValid = 1'b0;
  logic signed [19:0] ownI = '0, ownQ = '0, nbrI = '0, nbrQ = '0;
  logic [7:0] cfgDecM1 = '0, cfgPhase = '0, cfgTapsM1 = '0, cfgCoefOffset = '0;
  logic cfgBypass = 1'b0, cfgSrcSel = 1'b0;
  logic [7:0] coefAddr;
  logic signed [15:0] coefData;
  logic outValid, overrun;
  logic signed [39:0] outI, outQ;
  logic [15:0] testI, testQ;

  logic signed [15:0] coefMem [256];
  assign coefData = coefMem[coefAddr];

  always #4 clk = ~clk;  // 125 MHz

  polyfir_seq u_dut (
    .clk(clk), .rstN(rstN), .ownValid(ownValid), .ownI(ownI), .ownQ(ownQ),
    .nbrValid(nbrValid), .nbrI(nbrI), .nbrQ(nbrQ), .cfgDecM1(cfgDecM1),
    .cfgPhase(cfgPhase), .cfgTapsM1(cfgTapsM1), .cfgCoefOffset(cfgCoefOffset),
    .cfgBypass(cfgBypass), .cfgSrcSel(cfgSrcSel), .coefAddr(coefAddr),
    .coefData(coefData), .outValid(outValid), .outI(outI), .outQ(outQ),
    .overrun(overrun), .testI(testI), .testQ(testQ)
  );

  int nChecks = 0, nFail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  longint hI [4096];
  longint hQ [4096];
  int nH = 0, mPhaseCnt = 0, mPhaseSh = 0, busyEnd = 0;
  int wStart = 0, wOff = 0, wN = 0;
  bit wValid = 0;
  logic [15:0] mTestI = '0, mTestQ = '0;
  string curTag = "R4";
  int dueQ[$];
  longint eIQ[$];
  longint eQQ[$];
  string tagQ[$];
  int ovrQ[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input int n, input int salt);
    for (int i = 0; i < n; i++) begin
      logic signed [19:0] oi, oq, ni, nq, si, sq;
      int c;
      @(negedge clk);
      oi = 20'(((i * 37 + salt * 11) % 201) - 100);
      oq = 20'(((i * 53 + salt * 7) % 181) - 90);
      ni = 20'(((i * 29 + salt * 5) % 151) - 75) + 20'sd300;
      nq = 20'(((i * 17 + salt * 3) % 131) - 65) - 20'sd300;
      if (cfgBypass) begin
        oi = oi + 20'sh71230; oq = oq - 20'sh2a000;
        ni = ni + 20'sh3c560; nq = nq - 20'sh51000;
      end
      ownI = oi; ownQ = oq; nbrI = ni; nbrQ = nq;
      ownValid = 1'b1; nbrValid = 1'b1;
      c = cyc + 1;
      si = cfgSrcSel ? ni : oi;
      sq = cfgSrcSel ? nq : oq;
      if (cfgBypass) begin
        mTestI = si[19:4];
        mTestQ = sq[19:4];
      end else begin
        hI[nH] = longint'(si);
        hQ[nH] = longint'(sq);
        nH++;
        if (mPhaseCnt == mPhaseSh) begin
          if (c >= busyEnd) begin
            longint sI = 0, sQ = 0;
            int nTap = int'(cfgTapsM1);
            for (int k = 0; k <= nTap; k++) begin
              int idx = nH - 1 - k;
              longint cf = longint'(coefMem[(int'(cfgCoefOffset) + k) % 256]);
              if (idx >= 0) begin
                sI += hI[idx] * cf;
                sQ += hQ[idx] * cf;
              end
            end
            dueQ.push_back(c + nTap + 1);
            eIQ.push_back(sI);
            eQQ.push_back(sQ);
            tagQ.push_back(curTag);
            busyEnd  = c + nTap + 1;
            mPhaseSh = int'(cfgPhase);
            wStart = c; wOff = int'(cfgCoefOffset); wN = nTap; wValid = 1;
          end else begin
            ovrQ.push_back(c);
          end
        end
        mPhaseCnt = (mPhaseCnt >= int'(cfgDecM1)) ? 0 : mPhaseCnt + 1;
      end
    end
    @(negedge clk);
    ownValid = 1'b0; nbrValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      bit expO;
      while (dueQ.size() > 0 && dueQ[0] < cyc) begin
        chk(0, "R5", "missing output at cycle", longint'(cyc), longint'(dueQ[0]));
        void'(dueQ.pop_front()); void'(eIQ.pop_front());
        void'(eQQ.pop_front()); void'(tagQ.pop_front());
      end
      if (outValid) begin
        if (dueQ.size() > 0 && dueQ[0] == cyc) begin
          chk(longint'(outI) == eIQ[0], tagQ[0], "outI", longint'(outI), eIQ[0]);
          chk(longint'(outQ) == eQQ[0], tagQ[0], "outQ", longint'(outQ), eQQ[0]);
          void'(dueQ.pop_front()); void'(eIQ.pop_front());
          void'(eQQ.pop_front()); void'(tagQ.pop_front());
        end else begin
          chk(0, "R5/R8", "unexpected outValid at cycle", longint'(cyc), -1);
        end
      end
      while (ovrQ.size() > 0 && ovrQ[0] < cyc) void'(ovrQ.pop_front());
      expO = (ovrQ.size() > 0 && ovrQ[0] == cyc);
      if (expO) void'(ovrQ.pop_front());
      if (overrun || expO)
        chk(overrun == expO, "R9", "overrun", longint'(overrun), longint'(expO));
      if (wValid && cyc >= wStart && cyc <= wStart + wN)
        chk(int'(coefAddr) == (wOff + cyc - wStart) % 256, "R10", "coefAddr",
            longint'(coefAddr), longint'((wOff + cyc - wStart) % 256));
      chk(testI == mTestI && testQ == mTestQ, "R8", "test registers",
          longint'({testI, testQ}), longint'({mTestI, mTestQ}));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL R5 watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) coefMem[a] = 16'(((a * 13 + 7) % 61) - 30);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(outValid == 0, "R1", "outValid", longint'(outValid), 0);
    chk(overrun == 0, "R1", "overrun", longint'(overrun), 0);
    chk(testI == 0 && testQ == 0, "R1", "test registers", longint'({testI, testQ}), 0);

    // R4: basic filter, decimate by 4, 4 taps
    curTag = "R4";
    cfgDecM1 = 8'd3; cfgPhase = 8'd0; cfgTapsM1 = 8'd3; cfgCoefOffset = 8'd10;
    drive(16, 1); idle(10);

    // R3: decimate by 2, 2 taps
    curTag = "R3";
    cfgDecM1 = 8'd1; cfgTapsM1 = 8'd1; cfgCoefOffset = 8'd40;
    drive(10, 2); idle(10);

    // R10: coefficient address wrap past 255
    curTag = "R10";
    cfgDecM1 = 8'd5; cfgTapsM1 = 8'd5; cfgCoefOffset = 8'd254;
    drive(12, 3); idle(12);

    // R6: offset rewritten during a computation
    curTag = "R6";
    cfgDecM1 = 8'd7; cfgTapsM1 = 8'd7; cfgCoefOffset = 8'd20;
    drive(9, 4);
    cfgCoefOffset = 8'd100;
    drive(1, 5);
    cfgCoefOffset = 8'd180;
    drive(14, 6); idle(14);

    // R7: phase shadow
    curTag = "R7";
    cfgDecM1 = 8'd3; cfgTapsM1 = 8'd2; cfgCoefOffset = 8'd0; cfgPhase = 8'd2;
    drive(16, 7);
    cfgPhase = 8'd0;
    drive(8, 8); idle(10);

    // R2: neighbour stream selected
    curTag = "R2";
    cfgSrcSel = 1'b1; cfgCoefOffset = 8'd77;
    drive(12, 9); idle(10);
    cfgSrcSel = 1'b0;

    // R9: every sample requests a start while 4-tap computations run
    curTag = "R9";
    cfgDecM1 = 8'd0; cfgTapsM1 = 8'd3; cfgCoefOffset = 8'd5;
    drive(10, 10); idle(10);

    // R8: bypass into test registers, both sources
    curTag = "R8";
    cfgBypass = 1'b1;
    drive(6, 11);
    cfgSrcSel = 1'b1;
    drive(4, 12);
    cfgSrcSel = 1'b0; cfgBypass = 1'b0;
    idle(4);
    curTag = "R4";
    cfgTapsM1 = 8'd2; cfgCoefOffset = 8'd150;
    drive(6, 13); idle(10);

    chk(dueQ.size() == 0, "R5", "outputs left pending", longint'(dueQ.size()), 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule